// File: doc/BRIEF.md
# Configuration Mechanism One Translator

This block sits in a host bridge and turns processor I/O accesses aimed at two 32-bit ports into configuration cycles on the local expansion bus. The first port (I/O 0CF8h) holds an address register that selects an enable flag, a bus, a device, a function and a dword register. The second port (I/O 0CFCh to 0CFFh) is a window: a byte, word or dword access to it is forwarded as one configuration transaction when the address register points at a reachable device.

A forwarded access produces a type-0 address phase. The upper address lines carry a one-hot device select chosen by the device number. The lower bits carry the function and register numbers. The command says read or write, and the active-low byte enables follow the size and offset of the host access. The bus handshake itself lies outside the block. A pulse on `cfgStart` hands the captured phase to that logic, and a pulse on `cfgRespValid` reports that the transaction has ended. The host sees exactly one `ioDone` pulse per claimed access.

Top module: `cfg1_translator`

## Requirements
- R1: A dword write at offset 0 of the address port loads the address register. A read of the address port, of any size, returns {enable bit 31, zeros in 30:24, bus 23:16, device 15:11, function 10:8, register 7:2, zeros in 1:0}. After reset the register reads 00000000h.
- R2: A byte or word write to the address port completes with `ioDone` and leaves the register unchanged.
- R3: A data-port access is forwarded only when the enable is 1, the bus number is 0, the device number is from 1 to 20, and the access is aligned (byte at any offset, word at offset 0 or 2, dword at offset 0). It is then announced by a one-cycle `cfgStart` pulse in the cycle after the access.
- R4: The forwarded address has exactly one bit set among bits 31:11, namely bit 11+device, so device 0 never drives bit 11. Bits 10:8 carry the function, bits 7:2 the register, and bits 1:0 are 00.
- R5: The forwarded command is 1010 for a read and 1011 for a write.
- R6: The byte enables are active low, with bit k for byte lane k. A byte access at offset k clears only bit k. A word at offset 0 gives 1100 and at offset 2 gives 0011. A dword gives 0000.
- R7: A data-port access that is not forwarded completes with `ioDone` in the next cycle and produces no `cfgStart`. A read returns FFFFFFFFh; a write is discarded.
- R8: A forwarded access completes with `ioDone` in the cycle after `cfgRespValid`, never together with `cfgStart`. A read returns `cfgRespData`, and a write presents the host data on `cfgWdata`.
- R9: An access to any other I/O address gets no `ioDone` and no `cfgStart`.
- R10: After reset, `ioDone` and `cfgStart` are low and the byte enables read 1111.
- R11: A `cfgRespValid` pulse while no transaction is pending is ignored: no `ioDone` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioValid | input | 1 | Host I/O access request, one cycle |
| ioWrite | input | 1 | 1 = write, 0 = read |
| ioAddr | input | 16 | Host I/O byte address |
| ioSize | input | 2 | 0 byte, 1 word, 2 dword, 3 invalid |
| ioWdata | input | 32 | Host write data, lane aligned |
| ioDone | output | 1 | Access completed, one-cycle pulse |
| ioRdata | output | 32 | Read data, valid with ioDone |
| cfgStart | output | 1 | Configuration transaction start pulse |
| cfgAddr | output | 32 | Address-phase word |
| cfgCmd | output | 4 | Bus command |
| cfgByteEnN | output | 4 | Byte enables, active low |
| cfgWdata | output | 32 | Write data for the transaction |
| cfgRespValid | input | 1 | Transaction finished |
| cfgRespData | input | 32 | Read data returned by the bus |

## Verification
The assertions assume that the host issues no new `ioValid` while a forwarded transaction awaits `cfgRespValid`. They also assume that `cfgRespValid` is a single-cycle pulse. The bench keeps to both rules. Each access is started only after the previous one has reported `ioDone`, or after a fixed quiet gap for ignored addresses. The response is raised for exactly one cycle, after a delay of zero to two cycles following `cfgStart`, so that completion is seen both with and without wait states.

// File: rtl/cfg1_pkg.sv
package cfg1_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } ioSize_e;

  typedef struct packed {
    logic loadAddr;  // capture host dword into address register
    logic launch;    // capture address phase and command
    logic retAddr;   // return address register view
    logic retOnes;   // return all ones
    logic retResp;   // return bus response data
  } ctrlStrobe_t;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
endpackage

// File: rtl/cfg1_idsel_decode.sv
module cfg1_idsel_decode #(
  parameter int DevW = 5,
  parameter int SelW = 21
) (
  input  logic [DevW-1:0] devNum,
  output logic [SelW-1:0] selOneHot
);
  // Position 0 belongs to the bridge itself and is never selected.
  for (genvar g = 0; g < SelW; g++) begin : g_sel
    if (g == 0) begin : g_self
      assign selOneHot[g] = 1'b0;
    end else begin : g_dev
      assign selOneHot[g] = (devNum == DevW'(g));
    end
  end
endmodule

// File: rtl/cfg1_datapath.sv
module cfg1_datapath
  import cfg1_pkg::*;
#(
  parameter int IoW = 16,
  parameter int DataW = 32,
  parameter int IdselBase = 11,
  parameter logic [IoW-1:0] AddrPortIo = 16'h0CF8,
  parameter logic [IoW-1:0] DataPortIo = 16'h0CFC
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      stb,
  input  logic [IoW-1:0]   ioAddr,
  input  logic [1:0]       ioSize,
  input  logic             ioWrite,
  input  logic [DataW-1:0] ioWdata,
  input  logic [DataW-1:0] cfgRespData,
  output logic             hitAddrPort,
  output logic             hitDataPort,
  output logic             addrFullWr,
  output logic             fwdOk,
  output logic [DataW-1:0] ioRdata,
  output logic [DataW-1:0] cfgAddr,
  output logic [3:0]       cfgCmd,
  output logic [3:0]       cfgByteEnN,
  output logic [DataW-1:0] cfgWdata
);
  localparam int SelW = DataW - IdselBase;
  localparam int DevW = 5;

  logic       enReg;
  logic [7:0] busReg;
  logic [DevW-1:0] devReg;
  logic [2:0] fnReg;
  logic [5:0] regReg;

  logic [1:0]       offset;
  ioSize_e          sizeE;
  logic             aligned;
  logic [3:0]       laneEn;
  logic [SelW-1:0]  idselBits;
  logic [DataW-1:0] addrView;
  logic [DataW-1:0] phaseAddr;

  assign offset      = ioAddr[1:0];
  assign sizeE       = ioSize_e'(ioSize);
  assign hitAddrPort = (ioAddr[IoW-1:2] == AddrPortIo[IoW-1:2]);
  assign hitDataPort = (ioAddr[IoW-1:2] == DataPortIo[IoW-1:2]);
  assign addrFullWr  = hitAddrPort && (sizeE == SZ_DWORD) && (offset == 2'd0);

  always_comb begin
    aligned = 1'b0;
    laneEn  = 4'h0;
    unique case (sizeE)
      SZ_BYTE: begin
        aligned = 1'b1;
        laneEn  = 4'b0001 << offset;
      end
      SZ_WORD: begin
        aligned = !offset[0];
        laneEn  = 4'b0011 << offset;
      end
      SZ_DWORD: begin
        aligned = (offset == 2'd0);
        laneEn  = 4'b1111;
      end
      default: begin
        aligned = 1'b0;
        laneEn  = 4'h0;
      end
    endcase
  end

  cfg1_idsel_decode #(.DevW(DevW), .SelW(SelW)) u_idsel (
    .devNum   (devReg),
    .selOneHot(idselBits)
  );

  assign fwdOk = enReg && (busReg == 8'd0) && (|idselBits) && aligned;

  always_comb begin
    addrView        = '0;
    addrView[31]    = enReg;
    addrView[23:16] = busReg;
    addrView[15:11] = devReg;
    addrView[10:8]  = fnReg;
    addrView[7:2]   = regReg;
  end

  always_comb begin
    phaseAddr                      = '0;
    phaseAddr[DataW-1:IdselBase]   = idselBits;
    phaseAddr[10:8]                = fnReg;
    phaseAddr[7:2]                 = regReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      busReg <= '0;
      devReg <= '0;
      fnReg  <= '0;
      regReg <= '0;
    end else if (stb.loadAddr) begin
      enReg  <= ioWdata[31];
      busReg <= ioWdata[23:16];
      devReg <= ioWdata[15:11];
      fnReg  <= ioWdata[10:8];
      regReg <= ioWdata[7:2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAddr    <= '0;
      cfgCmd     <= '0;
      cfgByteEnN <= 4'hF;
      cfgWdata   <= '0;
    end else if (stb.launch) begin
      cfgAddr    <= phaseAddr;
      cfgCmd     <= ioWrite ? CMD_CFG_WR : CMD_CFG_RD;
      cfgByteEnN <= ~laneEn;
      cfgWdata   <= ioWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioRdata <= '0;
    end else if (stb.retAddr) begin
      ioRdata <= addrView;
    end else if (stb.retOnes) begin
      ioRdata <= '1;
    end else if (stb.retResp) begin
      ioRdata <= cfgRespData;
    end
  end

  // R6
  be_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.launch |=> (cfgByteEnN != 4'hF));

  // R4
  no_self_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.launch |=> !cfgAddr[IdselBase]);
endmodule

// File: rtl/cfg1_ctrl.sv
module cfg1_ctrl
  import cfg1_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioValid,
  input  logic        ioWrite,
  input  logic        hitAddrPort,
  input  logic        hitDataPort,
  input  logic        addrFullWr,
  input  logic        fwdOk,
  input  logic        cfgRespValid,
  output ctrlStrobe_t stb,
  output logic        cfgStart,
  output logic        ioDone
);
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} state_e;

  state_e state, stateNext;
  logic   pendRead, pendReadNext;
  logic   doneNext, startNext;

  always_comb begin
    stb          = '0;
    stateNext    = state;
    pendReadNext = pendRead;
    doneNext     = 1'b0;
    startNext    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ioValid) begin
          if (hitAddrPort) begin
            doneNext = 1'b1;
            if (ioWrite) stb.loadAddr = addrFullWr;
            else         stb.retAddr  = 1'b1;
          end else if (hitDataPort) begin
            if (fwdOk) begin
              stb.launch   = 1'b1;
              startNext    = 1'b1;
              pendReadNext = !ioWrite;
              stateNext    = ST_WAIT;
            end else begin
              doneNext    = 1'b1;
              stb.retOnes = !ioWrite;
            end
          end
        end
      end
      ST_WAIT: begin
        if (cfgRespValid) begin
          doneNext    = 1'b1;
          stb.retResp = pendRead;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendRead <= 1'b0;
      ioDone   <= 1'b0;
      cfgStart <= 1'b0;
    end else begin
      state    <= stateNext;
      pendRead <= pendReadNext;
      ioDone   <= doneNext;
      cfgStart <= startNext;
    end
  end

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |=> !cfgStart);

  // R8
  start_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgStart && ioDone));

  // R11
  stray_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cfgRespValid && !ioValid) |=> !ioDone);
endmodule

// File: rtl/cfg1_translator.sv
module cfg1_translator
  import cfg1_pkg::*;
#(
  parameter int IoW = 16,
  parameter int DataW = 32,
  parameter int IdselBase = 11,
  parameter logic [IoW-1:0] AddrPortIo = 16'h0CF8,
  parameter logic [IoW-1:0] DataPortIo = 16'h0CFC
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioValid,
  input  logic             ioWrite,
  input  logic [IoW-1:0]   ioAddr,
  input  logic [1:0]       ioSize,
  input  logic [DataW-1:0] ioWdata,
  output logic             ioDone,
  output logic [DataW-1:0] ioRdata,
  output logic             cfgStart,
  output logic [DataW-1:0] cfgAddr,
  output logic [3:0]       cfgCmd,
  output logic [3:0]       cfgByteEnN,
  output logic [DataW-1:0] cfgWdata,
  input  logic             cfgRespValid,
  input  logic [DataW-1:0] cfgRespData
);
  ctrlStrobe_t stb;
  logic hitAddrPort, hitDataPort, addrFullWr, fwdOk;

  cfg1_datapath #(
    .IoW(IoW), .DataW(DataW), .IdselBase(IdselBase),
    .AddrPortIo(AddrPortIo), .DataPortIo(DataPortIo)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .ioAddr(ioAddr), .ioSize(ioSize), .ioWrite(ioWrite), .ioWdata(ioWdata),
    .cfgRespData(cfgRespData),
    .hitAddrPort(hitAddrPort), .hitDataPort(hitDataPort),
    .addrFullWr(addrFullWr), .fwdOk(fwdOk),
    .ioRdata(ioRdata), .cfgAddr(cfgAddr), .cfgCmd(cfgCmd),
    .cfgByteEnN(cfgByteEnN), .cfgWdata(cfgWdata)
  );

  cfg1_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .ioValid(ioValid), .ioWrite(ioWrite),
    .hitAddrPort(hitAddrPort), .hitDataPort(hitDataPort),
    .addrFullWr(addrFullWr), .fwdOk(fwdOk),
    .cfgRespValid(cfgRespValid),
    .stb(stb), .cfgStart(cfgStart), .ioDone(ioDone)
  );

  // R4
  idsel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |-> ($onehot(cfgAddr[DataW-1:IdselBase]) && cfgAddr[1:0] == 2'b00));

  // R5
  cfg_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |-> (cfgCmd[3:1] == 3'b101));
endmodule

// File: tb/cfg1_translator_test.sv
module cfg1_translator_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioValid = 1'b0;
  logic        ioWrite = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [1:0]  ioSize = '0;
  logic [31:0] ioWdata = '0;
  logic        ioDone;
  logic [31:0] ioRdata;
  logic        cfgStart;
  logic [31:0] cfgAddr;
  logic [3:0]  cfgCmd;
  logic [3:0]  cfgByteEnN;
  logic [31:0] cfgWdata;
  logic        cfgRespValid = 1'b0;
  logic [31:0] cfgRespData = '0;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cfg1_translator uut (
    .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .ioSize(ioSize), .ioWdata(ioWdata),
    .ioDone(ioDone), .ioRdata(ioRdata), .cfgStart(cfgStart),
    .cfgAddr(cfgAddr), .cfgCmd(cfgCmd), .cfgByteEnN(cfgByteEnN),
    .cfgWdata(cfgWdata), .cfgRespValid(cfgRespValid), .cfgRespData(cfgRespData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Sizes: 0 byte, 1 word, 2 dword
  typedef struct packed {
    logic        wr;
    logic [15:0] port;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        fwd;
    logic [31:0] expAddr;
    logic [3:0]  expBe;
    logic [31:0] expRd;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0CF8, 2'd2, 32'h80000800, 1'b0, 32'h0, 4'h0, 32'h0},
    '{1'b0, 16'h0CF8, 2'd2, 32'h0,        1'b0, 32'h0, 4'h0, 32'h80000800},
    '{1'b0, 16'h0CFC, 2'd2, 32'h0,        1'b1, 32'h00001000, 4'b0000, 32'h0},
    '{1'b1, 16'h0CF8, 2'd2, 32'h80002B1C, 1'b0, 32'h0, 4'h0, 32'h0},
    '{1'b1, 16'h0CFE, 2'd1, 32'h12340000, 1'b1, 32'h0001031C, 4'b0011, 32'h0},
    '{1'b0, 16'h0CFD, 2'd0, 32'h0,        1'b1, 32'h0001031C, 4'b1101, 32'h0},
    '{1'b1, 16'h0CF8, 2'd1, 32'h00000000, 1'b0, 32'h0, 4'h0, 32'h0},
    '{1'b0, 16'h0CF8, 2'd2, 32'h0,        1'b0, 32'h0, 4'h0, 32'h80002B1C},
    '{1'b1, 16'h0CF8, 2'd2, 32'hFF00A803, 1'b0, 32'h0, 4'h0, 32'h0},
    '{1'b0, 16'h0CF8, 2'd2, 32'h0,        1'b0, 32'h0, 4'h0, 32'h8000A800},
    '{1'b0, 16'h0CFC, 2'd2, 32'h0,        1'b0, 32'h0, 4'h0, 32'hFFFFFFFF},
    '{1'b1, 16'h0CF8, 2'd2, 32'h8000A000, 1'b0, 32'h0, 4'h0, 32'h0},
    '{1'b0, 16'h0CFF, 2'd0, 32'h0,        1'b1, 32'h80000000, 4'b0111, 32'h0},
    '{1'b1, 16'h0CF8, 2'd2, 32'h80000000, 1'b0, 32'h0, 4'h0, 32'h0},
    '{1'b0, 16'h0CFC, 2'd2, 32'h0,        1'b0, 32'h0, 4'h0, 32'hFFFFFFFF},
    '{1'b1, 16'h0CF8, 2'd2, 32'h00000800, 1'b0, 32'h0, 4'h0, 32'h0},
    '{1'b0, 16'h0CFC, 2'd2, 32'h0,        1'b0, 32'h0, 4'h0, 32'hFFFFFFFF},
    '{1'b1, 16'h0CFC, 2'd2, 32'h11111111, 1'b0, 32'h0, 4'h0, 32'h0},
    '{1'b1, 16'h0CF8, 2'd2, 32'h80010800, 1'b0, 32'h0, 4'h0, 32'h0},
    '{1'b0, 16'h0CFC, 2'd2, 32'h0,        1'b0, 32'h0, 4'h0, 32'hFFFFFFFF},
    '{1'b1, 16'h0CF8, 2'd2, 32'h80000900, 1'b0, 32'h0, 4'h0, 32'h0},
    '{1'b0, 16'h0CFD, 2'd1, 32'h0,        1'b0, 32'h0, 4'h0, 32'hFFFFFFFF},
    '{1'b1, 16'h0CFC, 2'd2, 32'hDEADBEEF, 1'b1, 32'h00001100, 4'b0000, 32'h0},
    '{1'b0, 16'h0CFA, 2'd0, 32'h0,        1'b0, 32'h0, 4'h0, 32'h80000900},
    '{1'b0, 16'h0CFC, 2'd0, 32'h0,        1'b1, 32'h00001100, 4'b1110, 32'h0}
  };

  // One host access; responds to a forwarded cycle after respDelay cycles.
  task automatic doAccess(input logic wr, input logic [15:0] port, input logic [1:0] size,
                          input logic [31:0] wdata, input int respDelay,
                          output logic gotStart, output logic [31:0] sAddr,
                          output logic [3:0] sCmd, output logic [3:0] sBe,
                          output logic [31:0] sWdata, output logic gotDone,
                          output logic [31:0] rdata, output logic earlyDone);
    gotStart = 1'b0; sAddr = '0; sCmd = '0; sBe = '0; sWdata = '0;
    gotDone = 1'b0; rdata = '0; earlyDone = 1'b0;
    @(negedge clk);
    ioValid = 1'b1; ioWrite = wr; ioAddr = port; ioSize = size; ioWdata = wdata;
    @(negedge clk);
    ioValid = 1'b0;
    if (cfgStart) begin
      gotStart = 1'b1;
      sAddr = cfgAddr; sCmd = cfgCmd; sBe = cfgByteEnN; sWdata = cfgWdata;
      for (int k = 0; k < respDelay; k++) begin
        @(negedge clk);
        if (ioDone) earlyDone = 1'b1;
      end
      cfgRespValid = 1'b1;
      cfgRespData  = ~sAddr;
      @(negedge clk);
      cfgRespValid = 1'b0;
      gotDone = ioDone;
      rdata   = ioRdata;
    end else begin
      gotDone = ioDone;
      rdata   = ioRdata;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nChecks++;
        nFail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
        $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
        $finish;
      end
    end
  end

  initial begin
    logic gs, gd, ed;
    logic [31:0] sa, sw, rd;
    logic [3:0] sc, sb;
    logic sawDone, sawStart;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ioDone", {31'b0, ioDone}, 32'h0);
    chk("R10 cfgStart", {31'b0, cfgStart}, 32'h0);
    chk("R10 byte enables", {28'b0, cfgByteEnN}, 32'hF);
    rstN = 1'b1;
    @(negedge clk);
    doAccess(1'b0, 16'h0CF8, 2'd2, '0, 0, gs, sa, sc, sb, sw, gd, rd, ed);
    chk("R10 R1 address reg after reset", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      doAccess(v.wr, v.port, v.size, v.wdata, i % 3, gs, sa, sc, sb, sw, gd, rd, ed);
      chk($sformatf("R3 vec%0d forwarded", i), {31'b0, gs}, {31'b0, v.fwd});
      chk($sformatf("R7 R8 vec%0d done", i), {31'b0, gd}, 32'h1);
      if (v.fwd) begin
        chk($sformatf("R4 vec%0d address phase", i), sa, v.expAddr);
        chk($sformatf("R5 vec%0d command", i), {28'b0, sc}, {28'b0, v.wr ? 4'b1011 : 4'b1010});
        chk($sformatf("R6 vec%0d byte enables", i), {28'b0, sb}, {28'b0, v.expBe});
        chk($sformatf("R8 vec%0d no early done", i), {31'b0, ed}, 32'h0);
        if (v.wr) chk($sformatf("R8 vec%0d write data", i), sw, v.wdata);
        else      chk($sformatf("R8 vec%0d read data", i), rd, ~v.expAddr);
      end else if (!v.wr) begin
        if (v.port[15:2] == 14'h033E)
          chk($sformatf("R1 R2 vec%0d address port read", i), rd, v.expRd);
        else
          chk($sformatf("R7 vec%0d unforwarded read", i), rd, v.expRd);
      end
    end

    // R9 other I/O address ignored, then address register unchanged
    @(negedge clk);
    ioValid = 1'b1; ioWrite = 1'b1; ioAddr = 16'h0080; ioSize = 2'd2; ioWdata = 32'h80001800;
    @(negedge clk);
    ioValid = 1'b0;
    sawDone = 1'b0; sawStart = 1'b0;
    for (int k = 0; k < 5; k++) begin
      if (ioDone) sawDone = 1'b1;
      if (cfgStart) sawStart = 1'b1;
      @(negedge clk);
    end
    chk("R9 no done on foreign port", {31'b0, sawDone}, 32'h0);
    chk("R9 no cycle on foreign port", {31'b0, sawStart}, 32'h0);
    doAccess(1'b0, 16'h0CF8, 2'd2, '0, 0, gs, sa, sc, sb, sw, gd, rd, ed);
    chk("R9 address reg unchanged", rd, 32'h80000900);

    // R11 stray response while idle
    @(negedge clk);
    cfgRespValid = 1'b1; cfgRespData = 32'h12345678;
    @(negedge clk);
    cfgRespValid = 1'b0;
    sawDone = ioDone;
    @(negedge clk);
    if (ioDone) sawDone = 1'b1;
    chk("R11 stray response ignored", {31'b0, sawDone}, 32'h0);

    // R3 word at offset 2 with dword size misaligned -> not forwarded
    doAccess(1'b0, 16'h0CFE, 2'd2, '0, 0, gs, sa, sc, sb, sw, gd, rd, ed);
    chk("R3 misaligned dword not forwarded", {31'b0, gs}, 32'h0);
    chk("R7 misaligned dword returns ones", rd, 32'hFFFFFFFF);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule